// File: doc/BRIEF.md
# Multi-Core Routed Level Interrupt Controller

This block collects 32 level-sensitive interrupt sources and drives 16 interrupt outputs. The outputs form a grid of 4 processor cores, each with 4 interrupt lines. Every source owns a one-byte routing register. The low nibble of that byte chooses which cores the source reaches, and the high nibble chooses which of a core's lines it reaches. An enable mask gates each source. Software changes the mask through two write-one registers: one sets bits and one clears them.

Software reaches the block through a simple single-cycle register bus. Each request carries a valid flag, a write flag, a 7-bit byte address, a size flag (byte or word), 32-bit write data, and 32-bit read data that is returned in the same cycle. Nothing is latched. The masked status and the per-core status views are always recomputed from the current source levels, the enable mask and the routing bytes.

A core/line output is the cross-product of two independent conditions. The core must see at least one of its sources active, and at least one active source (not necessarily the same one) must be routed to that line. The outputs are registered.

Top module: `core_irq_router`

## Requirements
- R1: After reset, all routing bytes, the enable mask and all 16 outputs are zero.
- R2: A word read at offset 0x20 returns the source levels ANDed with the enable mask. The value follows the inputs in the same cycle and holds no past value.
- R3: Byte accesses at offsets 0x00 to 0x1F read and write the routing byte of source N at offset N. In that byte, bit c (0 to 3) selects core c and bit 4+l selects line l (0 to 3). A byte read returns the value in bits 7:0, with the upper bits zero.
- R4: A word read at 0x24 returns the enable mask. A word write at 0x28 ORs the write data into the mask.
- R5: A word write at 0x2C clears every enable bit where the write data holds a one. All other enable bits keep their value.
- R6: A word read at 0x40 + 4·c returns the masked status bits of the sources whose routing byte has core bit c set. Writes to these offsets change nothing.
- R7: Output 4·c + l is high exactly when both of these hold: core c's per-core status is nonzero, and some source that is both enabled and active has line bit l set.
- R8: The outputs are registered. After an input level change, they update at the next rising edge. After a register write, they show the new state from the edge that performs the write.
- R9: Mismatched accesses are ignored. This covers byte accesses at or above 0x20, word accesses that are not 4-byte aligned, and word accesses to the routing range. Such writes change no state, and such reads return 0.
- R10: Word reads of 0x28, 0x2C, unassigned offsets and offsets at or above 0x64 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 32 | Level-sensitive interrupt sources |
| bus_vld | input | 1 | Bus request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address within the register window |
| bus_byte | input | 1 | 1 = byte-size access, 0 = word-size access |
| bus_wdata | input | 32 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq_out | output | 16 | Interrupt outputs, index 4·core + line |

## Verification
The assertions assume the following about the inputs:
- Each bus request stays stable across the clock edge that samples it.
- The source levels change synchronously with the clock.
- No request is issued while reset is high.

The bench keeps within these assumptions. It drives every input at the falling edge, holds each write for exactly one rising edge, and samples read data a short delay after driving. It releases reset before the first access. Read strobes are dropped before the next rising edge, so reads never overlap a write.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;
  localparam int ADDR_W  = 7;
  localparam int ROUTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 7'h20;
  localparam logic [ADDR_W-1:0] OFS_EN     = 7'h24;
  localparam logic [ADDR_W-1:0] OFS_SET    = 7'h28;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 7'h2C;
  localparam logic [ADDR_W-1:0] OFS_CORE0  = 7'h40;
  localparam logic [ADDR_W-1:0] WIN_END    = 7'h64;
endpackage

// File: rtl/cir_route_bank.sv
module cir_route_bank #(
  parameter int N_SRC = 32,
  parameter int RW    = 8,
  parameter int IW    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [RW-1:0]     wdata,
  output logic [N_SRC*RW-1:0] route_q,
  output logic [N_SRC*RW-1:0] route_d
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_byte
    logic [RW-1:0] cur_q;
    logic [RW-1:0] nxt;
    assign nxt = (we && idx == IW'(i)) ? wdata : cur_q;
    always_ff @(posedge clk) begin
      if (rst) cur_q <= '0;
      else     cur_q <= nxt;
    end
    assign route_q[i*RW +: RW] = cur_q;
    assign route_d[i*RW +: RW] = nxt;
  end
endmodule

// File: rtl/cir_enable_reg.sv
module cir_enable_reg #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] en_d
);
  logic [N_SRC-1:0] set_bits;
  logic [N_SRC-1:0] clr_bits;

  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;
  assign en_d     = (en_q | set_bits) & ~clr_bits;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/cir_fanout.sv
module cir_fanout #(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4,
  parameter int RW     = 8
) (
  input  logic [N_SRC-1:0]        src_lvl,
  input  logic [N_SRC-1:0]        en,
  input  logic [N_SRC*RW-1:0]     route,
  output logic [N_SRC-1:0]        status,
  output logic [N_CORE*N_SRC-1:0] core_stat,
  output logic [N_CORE*N_LINE-1:0] irq
);
  logic [N_CORE-1:0][N_SRC-1:0] core_sel;
  logic [N_LINE-1:0][N_SRC-1:0] line_sel;
  logic [N_CORE-1:0]            core_hit;
  logic [N_LINE-1:0]            line_hit;

  assign status = src_lvl & en;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    for (genvar c = 0; c < N_CORE; c++) begin : g_c
      assign core_sel[c][i] = route[i*RW + c];
    end
    for (genvar l = 0; l < N_LINE; l++) begin : g_l
      assign line_sel[l][i] = route[i*RW + N_CORE + l];
    end
  end

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    assign core_stat[c*N_SRC +: N_SRC] = status & core_sel[c];
    assign core_hit[c] = |(status & core_sel[c]);
  end

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    assign line_hit[l] = |(status & line_sel[l]);
  end

  for (genvar c = 0; c < N_CORE; c++) begin : g_row
    for (genvar l = 0; l < N_LINE; l++) begin : g_col
      assign irq[c*N_LINE + l] = core_hit[c] & line_hit[l];
    end
  end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import core_irq_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4,
  parameter int DW     = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_SRC-1:0]         src_lvl,
  input  logic                     bus_vld,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_byte,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  output logic [N_CORE*N_LINE-1:0] irq_out
);
  localparam int IW  = $clog2(N_SRC);
  localparam int CIW = (N_CORE > 1) ? $clog2(N_CORE) : 1;
  localparam logic [ADDR_W-1:0] ROUTE_END = ADDR_W'(N_SRC);
  localparam logic [ADDR_W-1:0] CORE_END  = OFS_CORE0 + ADDR_W'(4 * N_CORE);

  // address decode
  logic byte_hit, word_ok, core_hit;
  logic [ADDR_W-1:0] core_off;
  logic [CIW-1:0]    core_idx;
  logic [IW-1:0]     route_idx;

  assign byte_hit  = bus_vld && bus_byte && (bus_addr < ROUTE_END);
  assign word_ok   = bus_vld && !bus_byte && (bus_addr[1:0] == 2'b00) && (bus_addr < WIN_END);
  assign core_hit  = word_ok && (bus_addr >= OFS_CORE0) && (bus_addr < CORE_END);
  assign core_off  = bus_addr - OFS_CORE0;
  assign core_idx  = core_off[2 +: CIW];
  assign route_idx = bus_addr[IW-1:0];

  // state
  logic [N_SRC*ROUTE_W-1:0] route_q, route_d;
  logic [N_SRC-1:0]         en_q, en_d;

  cir_route_bank #(.N_SRC(N_SRC), .RW(ROUTE_W), .IW(IW)) u_route (
    .clk     (clk),
    .rst     (rst),
    .we      (byte_hit && bus_wr),
    .idx     (route_idx),
    .wdata   (bus_wdata[ROUTE_W-1:0]),
    .route_q (route_q),
    .route_d (route_d)
  );

  cir_enable_reg #(.N_SRC(N_SRC)) u_en (
    .clk    (clk),
    .rst    (rst),
    .set_we (word_ok && bus_wr && bus_addr == OFS_SET),
    .clr_we (word_ok && bus_wr && bus_addr == OFS_CLR),
    .wdata  (bus_wdata[N_SRC-1:0]),
    .en_q   (en_q),
    .en_d   (en_d)
  );

  // routing evaluated on next-state values; equals current state when no write
  logic [N_SRC-1:0]          status;
  logic [N_CORE*N_SRC-1:0]   core_stat;
  logic [N_CORE*N_LINE-1:0]  irq_d;

  cir_fanout #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE), .RW(ROUTE_W)) u_fan (
    .src_lvl   (src_lvl),
    .en        (en_d),
    .route     (route_d),
    .status    (status),
    .core_stat (core_stat),
    .irq       (irq_d)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= irq_d;
  end

  // read mux (single cycle)
  always_comb begin
    bus_rdata = '0;
    if (!bus_wr) begin
      if (byte_hit) begin
        bus_rdata = DW'(route_q[route_idx*ROUTE_W +: ROUTE_W]);
      end else if (core_hit) begin
        bus_rdata = DW'(core_stat[core_idx*N_SRC +: N_SRC]);
      end else if (word_ok && bus_addr == OFS_STATUS) begin
        bus_rdata = DW'(status);
      end else if (word_ok && bus_addr == OFS_EN) begin
        bus_rdata = DW'(en_q);
      end
    end
  end
endmodule

// File: rtl/core_irq_router_chk.sv
module core_irq_router_chk #(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4,
  parameter int DW     = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic [N_SRC-1:0]         src_lvl,
  input logic                     bus_vld,
  input logic                     bus_wr,
  input logic [6:0]               bus_addr,
  input logic                     bus_byte,
  input logic [DW-1:0]            bus_wdata,
  input logic [DW-1:0]            bus_rdata,
  input logic [N_CORE*N_LINE-1:0] irq_out,
  input logic [N_SRC-1:0]         en_q,
  input logic [N_SRC*8-1:0]       route_q
);
  logic wr_word;
  assign wr_word = bus_vld && bus_wr && !bus_byte;

  a_r4_set_or: assert property (@(posedge clk) disable iff (rst)
    (wr_word && bus_addr == 7'h28) |=>
      ((en_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

  a_r5_clear_ones: assert property (@(posedge clk) disable iff (rst)
    (wr_word && bus_addr == 7'h2C) |=> ((en_q & $past(bus_wdata[N_SRC-1:0])) == '0));

  a_r9_word_route_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_word && bus_addr < 7'h20) |=> $stable(route_q));

  a_r6_core_view_readonly: assert property (@(posedge clk) disable iff (rst)
    (wr_word && bus_addr >= 7'h40 && bus_addr < 7'h50) |=> ($stable(en_q) && $stable(route_q)));

  a_r9_byte_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_vld && !bus_wr && bus_byte && bus_addr >= 7'h20) |-> (bus_rdata == '0));

  a_r2_status_view: assert property (@(posedge clk) disable iff (rst)
    (bus_vld && !bus_wr && !bus_byte && bus_addr == 7'h20) |-> (bus_rdata == DW'(src_lvl & en_q)));

  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0 && !(bus_vld && bus_wr)) |=> (irq_out == '0));
endmodule

bind core_irq_router core_irq_router_chk #(
  .N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE), .DW(DW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_lvl   (src_lvl),
  .bus_vld   (bus_vld),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_byte  (bus_byte),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .en_q      (en_q),
  .route_q   (route_q)
);

// File: tb/sim_core_irq_router.sv
`timescale 1ns/1ps
module sim_core_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_lvl = '0;
  logic        bus_vld = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  m_rt [32];
  logic [31:0] m_en;

  always #10 clk = ~clk;

  core_irq_router u0 (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [31:0] exp_status();
    return src_lvl & m_en;
  endfunction

  function automatic logic [31:0] exp_core(int c);
    logic [31:0] s = exp_status();
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) if (s[i] && m_rt[i][c]) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] exp_irq();
    logic [31:0] s = exp_status();
    logic [15:0] r = '0;
    for (int c = 0; c < 4; c++)
      for (int l = 0; l < 4; l++) begin
        bit lh = 0;
        for (int i = 0; i < 32; i++) if (s[i] && m_rt[i][4+l]) lh = 1;
        r[4*c+l] = (exp_core(c) != 0) && lh;
      end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag);
    check(irq_out === exp_irq(), tag, {16'h0, irq_out}, {16'h0, exp_irq()});
  endtask

  task automatic bus_write(input logic [6:0] a, input bit b, input logic [31:0] d);
    @(negedge clk);
    bus_vld = 1; bus_wr = 1; bus_addr = a; bus_byte = b; bus_wdata = d;
    @(negedge clk);
    bus_vld = 0; bus_wr = 0;
    if (b && a < 7'h20) m_rt[a[4:0]] = d[7:0];
    else if (!b && a[1:0] == 2'b00) begin
      if (a == 7'h28) m_en = m_en | d;
      else if (a == 7'h2C) m_en = m_en & ~d;
    end
  endtask

  task automatic rd(input logic [6:0] a, input bit b, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_vld = 1; bus_wr = 0; bus_addr = a; bus_byte = b;
    #1;
    check(bus_rdata === exp, tag, bus_rdata, exp);
    bus_vld = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    logic [31:0] pat;
    for (int i = 0; i < 32; i++) m_rt[i] = '0;
    m_en = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check_out("R1 outputs after reset");
    rd(7'h24, 0, 32'h0, "R1 enable after reset");
    for (int i = 0; i < 32; i++) rd(7'(i), 1, 32'h0, "R1 routing byte after reset");

    // R3 routing byte sweep
    for (int i = 0; i < 32; i++) bus_write(7'(i), 1, 32'hAB00_0000 | ((i * 37 + 5) & 8'hFF));
    for (int i = 0; i < 32; i++) rd(7'(i), 1, {24'h0, m_rt[i]}, "R3 routing readback");

    // R4 / R5 enable set and clear, outputs follow on write edge (R8)
    src_lvl = 32'hFFFF_FFFF;
    bus_write(7'h28, 0, 32'h0000_FFFF);
    check_out("R8 outputs on set write edge");
    rd(7'h24, 0, 32'h0000_FFFF, "R4 enable after set");
    bus_write(7'h28, 0, 32'hF0F0_0000);
    rd(7'h24, 0, 32'hF0F0_FFFF, "R4 enable OR accumulates");
    bus_write(7'h2C, 0, 32'h00FF_00FF);
    rd(7'h24, 0, 32'hF000_FF00, "R5 enable after clear");
    check_out("R8 outputs on clear write edge");
    bus_write(7'h28, 0, 32'hFFFF_FFFF);

    // R2 / R6 / R7 / R8 source sweep
    for (int k = 0; k < 48; k++) begin
      pat = (k < 32) ? (32'h1 << k) : (32'h9E37_79B9 * (k + 1)) ^ (32'h1 << (k % 7));
      prev = exp_irq();
      @(negedge clk);
      src_lvl = pat;
      check(irq_out === prev, "R8 outputs hold until edge", {16'h0, irq_out}, {16'h0, prev});
      rd(7'h20, 0, exp_status(), "R2 status follows inputs");
      check_out("R7 outputs after input change");
      for (int c = 0; c < 4; c++) rd(7'(8'h40 + 4 * c), 0, exp_core(c), "R6 per-core status");
    end

    // R7 cross-product
    for (int i = 0; i < 32; i++) bus_write(7'(i), 1, 32'h0);
    bus_write(7'h03, 1, 32'h11);
    bus_write(7'h07, 1, 32'h22);
    @(negedge clk);
    src_lvl = 32'h0000_0088;
    @(negedge clk);
    check(irq_out === 16'h0033, "R7 cross-product grid", {16'h0, irq_out}, 32'h33);
    @(negedge clk);
    src_lvl = 32'h0000_0008;
    @(negedge clk);
    check(irq_out === 16'h0001, "R7 single source", {16'h0, irq_out}, 32'h1);

    // R6 read-only per-core view, R9 mismatched accesses
    src_lvl = 32'hFFFF_FFFF;
    bus_write(7'h40, 0, 32'hFFFF_FFFF);
    rd(7'h40, 0, exp_core(0), "R6 per-core write ignored");
    bus_write(7'h28, 1, 32'hFF);
    bus_write(7'h2C, 1, 32'hFF);
    rd(7'h24, 0, m_en, "R9 byte write to enable ignored");
    bus_write(7'h00, 0, 32'h5A5A_5A5A);
    rd(7'h00, 1, 32'h0, "R9 word write to routing ignored");
    rd(7'h03, 1, 32'h11, "R9 routing byte intact");
    bus_write(7'h2E, 0, 32'hFFFF_FFFF);
    rd(7'h24, 0, 32'hFFFF_FFFF, "R9 unaligned clear ignored");
    rd(7'h20, 1, 32'h0, "R9 byte read of status is zero");
    rd(7'h22, 0, 32'h0, "R9 unaligned word read is zero");
    rd(7'h04, 0, 32'h0, "R9 word read of routing is zero");
    check_out("R9 outputs unchanged by ignored writes");

    // R10 holes and out-of-window
    rd(7'h28, 0, 32'h0, "R10 set offset reads zero");
    rd(7'h2C, 0, 32'h0, "R10 clear offset reads zero");
    rd(7'h30, 0, 32'h0, "R10 hole reads zero");
    rd(7'h64, 0, 32'h0, "R10 window end reads zero");
    rd(7'h7C, 0, 32'h0, "R10 high offset reads zero");

    // R5 full clear silences outputs
    bus_write(7'h2C, 0, 32'hFFFF_FFFF);
    check(irq_out === 16'h0, "R5 full clear silences outputs", {16'h0, irq_out}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule